// File: doc/BRIEF.md
# Byte-Serial SPI Master with Two-Bit Write Mode

This block turns a stream of byte commands into SPI bus activity. Each byte handed over on a valid/ready port is shifted out most significant bit first while a return byte is sampled from MISO. A command can instead ask for a two-bit-per-clock write: the upper bit of each pair goes on MOSI and the lower bit on a third select pin, CS2, which then acts as a second data line. That halves the clocks per byte.

Two chip-select lines are driven. The device index picks one of them. An option flips the select sense so that the chosen device sees a high level. The SCK rate comes from a divider input that is clamped to at least 1. At a divider of 0 the first bit would be sampled too early. A byte can also be flagged as a check: the block sends 0x00, compares the returned byte with the supplied one, and cuts the transfer short at the first difference. It then reports how many bytes of the transfer were good. A byte flagged as the last one closes the transfer, releases the selects, and holds them released for a fixed gap before the next byte may start.

Top module: `spi_dual_master`

## Requirements
- R1: In normal mode a byte takes 8 SCK periods, and MOSI carries bit 7 first down to bit 0.
- R2: With `cmd_fast` set, a byte takes 4 SCK periods. MOSI and CS2 carry the pairs (7,6), (5,4), (3,2), (1,0) in that order, the higher bit of each pair on MOSI. In normal mode CS2 keeps its value.
- R3: MOSI and CS2 change only while SCK is low, and each SCK period has a low phase of D+1 cycles followed by a high phase of D+1 cycles. D is the effective divider.
- R4: The effective divider D equals `clk_div`, except that `clk_div` = 0 gives D = 1.
- R5: While a transfer is open, the selected line is at the select level and the other line is at the opposite level. With `dev_sel` = 2 the selected line is CS1; every other index selects CS0. The select level is low, or high when `sel_high` = 1. Index and sense are latched by the first byte of a transfer.
- R6: After reset and after each transfer closes, CS0, CS1 and CS2 are high.
- R7: When `cmd_has_tx` = 0, or `cmd_verify` = 1, the byte shifted out is 0x00.
- R8: MISO is sampled on each SCK rising edge. It is shifted in MSB first. In normal mode the byte appears on `rx_data`, with a one-cycle `rx_valid` pulse in the cycle after the last SCK falling edge. Fast-mode bytes give no `rx_valid`.
- R9: In a checked byte (`cmd_verify` = 1) a received value different from `cmd_data` ends the transfer at once. `done` is raised with `done_fail` = 1 and `done_count` = the number of earlier good bytes. The remaining commands up to and including the next one with `cmd_last` are accepted without bus activity.
- R10: After a transfer closes, `cmd_ready` stays low for GAP_CYC cycles, so the selects stay high for at least that long.
- R11: A byte with `cmd_last` = 1 and no mismatch closes the transfer with `done` = 1, `done_fail` = 0 and `done_count` = the number of bytes in the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_div | input | DIV_W | SCK divider, 0 treated as 1 |
| dev_sel | input | 2 | Device index; 2 selects CS1 |
| sel_high | input | 1 | Select level is high when 1 |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | 8 | Byte to send, or expected byte when checking |
| cmd_has_tx | input | 1 | 0 sends 0x00 |
| cmd_fast | input | 1 | Two bits per SCK period |
| cmd_verify | input | 1 | Compare the received byte with cmd_data |
| cmd_last | input | 1 | Close the transfer after this byte |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| done | output | 1 | Transfer closed pulse |
| done_fail | output | 1 | Transfer closed by a mismatch |
| done_count | output | CNT_W | Good bytes in the closed transfer |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out, upper bit of a pair |
| miso | input | 1 | Serial data in |
| cs0 | output | 1 | Select line 0 |
| cs1 | output | 1 | Select line 1 |
| cs2 | output | 1 | Spare select, lower bit of a pair in fast mode |

## Verification
The hardest state to reach is a mismatch in the middle of a checked transfer. After it the block must report a short count, swallow the rest of the transfer silently, and then resume cleanly. The bench reaches it with a slave model that answers from a byte list. One answer in that list differs from the expected byte, and further commands, ending in a last-flagged one, are queued behind the failing byte. A following transfer then shows that the skip state has ended.

// File: rtl/spi_dual_master.sv
module spi_dual_master #(
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 5,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [1:0]       dev_sel,
  input  logic             sel_high,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_has_tx,
  input  logic             cmd_fast,
  input  logic             cmd_verify,
  input  logic             cmd_last,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             done_fail,
  output logic [CNT_W-1:0] done_count,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             cs0,
  output logic             cs1,
  output logic             cs2
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_INIT = GW'(GAP_CYC);

  logic             busy, act, pol, use1, fast, vfy, endf, skip;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       steps;
  logic [7:0]       txs, rxs, expb;
  logic [GW-1:0]    gap;
  logic [CNT_W-1:0] okc;

  wire [DIV_W-1:0] div_e  = (clk_div == '0) ? DIV_W'(1) : clk_div;
  wire             accept = cmd_valid && cmd_ready;
  wire             mism   = vfy && (rxs != expb);
  wire [7:0]       txb    = (cmd_has_tx && !cmd_verify) ? cmd_data : 8'h00;

  assign cmd_ready = !busy && (gap == '0);
  assign cs0 = act ? (use1 ? !pol : pol) : 1'b1;
  assign cs1 = act ? (use1 ? pol : !pol) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; act <= 1'b0; pol <= 1'b0; use1 <= 1'b0;
      fast <= 1'b0; vfy <= 1'b0; endf <= 1'b0; skip <= 1'b0;
      cnt <= '0; steps <= '0; txs <= '0; rxs <= '0; expb <= '0;
      gap <= '0; okc <= '0;
      rx_valid <= 1'b0; rx_data <= '0;
      done <= 1'b0; done_fail <= 1'b0; done_count <= '0;
      sck <= 1'b0; mosi <= 1'b0; cs2 <= 1'b1;
    end else begin
      rx_valid  <= 1'b0;
      done      <= 1'b0;
      done_fail <= 1'b0;
      if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= div_e;
          if (!sck) begin
            sck <= 1'b1;
            rxs <= {rxs[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (steps == 4'd1) begin
              busy     <= 1'b0;
              rx_valid <= !fast;
              rx_data  <= rxs;
              if (mism || endf) begin
                act        <= 1'b0;
                cs2        <= 1'b1;
                gap        <= GAP_INIT;
                done       <= 1'b1;
                done_fail  <= mism;
                done_count <= mism ? okc : okc + 1'b1;
                okc        <= '0;
                skip       <= mism && !endf;
              end else begin
                okc <= okc + 1'b1;
              end
            end else begin
              steps <= steps - 1'b1;
              if (fast) begin
                txs  <= {txs[5:0], 2'b00};
                mosi <= txs[5];
                cs2  <= txs[4];
              end else begin
                txs  <= {txs[6:0], 1'b0};
                mosi <= txs[6];
              end
            end
          end
        end
      end else if (gap != '0) begin
        gap <= gap - 1'b1;
      end else if (accept) begin
        if (skip) begin
          if (cmd_last) skip <= 1'b0;
        end else begin
          busy <= 1'b1;
          act  <= 1'b1;
          if (!act) begin
            use1 <= (dev_sel == 2'd2);
            pol  <= sel_high;
          end
          txs   <= txb;
          mosi  <= txb[7];
          if (cmd_fast) cs2 <= txb[6];
          fast  <= cmd_fast;
          vfy   <= cmd_verify;
          endf  <= cmd_last;
          expb  <= cmd_data;
          steps <= cmd_fast ? 4'd4 : 4'd8;
          cnt   <= div_e;
          sck   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_dual_master_chk.sv
module spi_dual_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic cs0,
  input logic cs1,
  input logic cs2,
  input logic cmd_ready,
  input logic rx_valid,
  input logic done,
  input logic done_fail
);
  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi) && $stable(cs2));

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !sck);

  p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> sck);

  p_one_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs0 && !cs1));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs0 && cs1 && cs2);

  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_fail_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |-> done);

  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !cmd_ready);
endmodule

bind spi_dual_master spi_dual_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs0(cs0), .cs1(cs1),
  .cs2(cs2), .cmd_ready(cmd_ready), .rx_valid(rx_valid), .done(done),
  .done_fail(done_fail)
);

// File: tb/spi_dual_master_test.sv
module spi_dual_master_test;
  localparam int GAP = 5;

  logic clk = 0, rst_n = 0;
  logic [7:0] clk_div = 0;
  logic [1:0] dev_sel = 0;
  logic sel_high = 0, cmd_valid = 0, cmd_has_tx = 0, cmd_fast = 0;
  logic cmd_verify = 0, cmd_last = 0, miso = 0;
  logic [7:0] cmd_data = 0;
  logic cmd_ready, rx_valid, done, done_fail, sck, mosi, cs0, cs1, cs2;
  logic [7:0] rx_data, done_count;

  spi_dual_master #(.DIV_W(8), .GAP_CYC(GAP), .CNT_W(8)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // slave: answers from a byte list, MSB first, advancing on SCK rises
  int resp[$];
  int sbit = 0;
  logic prev_sck = 0;
  always @(negedge clk) begin
    if (sck && !prev_sck) sbit++;
    prev_sck = sck;
    if (sbit / 8 < resp.size()) miso = resp[sbit/8][7 - sbit % 8];
    else miso = 0;
  end

  // behavioural reference model
  int m_t, m_steps, m_gap, m_ok, m_txb, m_exp, m_rx, m_rxd, m_cnt;
  bit m_busy, m_act, m_dev2, m_pol, m_fast, m_vfy, m_last, m_skip;
  bit m_sck, m_mosi, m_cs2, m_rv, m_dn, m_fail, m_live;
  always @(posedge clk) begin
    int d, h, p, w, k;
    bit mis;
    m_rv = 0; m_dn = 0; m_fail = 0;
    if (!rst_n) begin
      m_busy = 0; m_act = 0; m_gap = 0; m_ok = 0; m_skip = 0;
      m_sck = 0; m_mosi = 0; m_cs2 = 1; m_live = 0;
    end else begin
      m_live = 1;
      d = (clk_div == 0) ? 1 : int'(clk_div);
      h = d + 1; p = 2 * h;
      if (m_busy) begin
        m_t++;
        if (m_t == m_steps * p) begin
          m_busy = 0; m_sck = 0;
          m_rv = !m_fast; m_rxd = m_rx;
          mis = m_vfy && (m_rx != m_exp);
          if (!mis) m_ok++;
          if (mis || m_last) begin
            m_dn = 1; m_fail = mis; m_cnt = m_ok; m_ok = 0;
            m_act = 0; m_cs2 = 1; m_gap = GAP; m_skip = mis && !m_last;
          end
        end else begin
          w = m_t % p; k = m_t / p;
          m_sck = (w >= h);
          if (w == h) m_rx = ((m_rx << 1) | int'(miso)) & 255;
          if (w == 0) begin
            if (m_fast) begin
              m_mosi = m_txb[7 - 2*k]; m_cs2 = m_txb[6 - 2*k];
            end else m_mosi = m_txb[7 - k];
          end
        end
      end else if (m_gap > 0) begin
        m_gap--;
      end else if (cmd_valid) begin
        if (m_skip) begin
          if (cmd_last) m_skip = 0;
        end else begin
          m_busy = 1; m_t = 0;
          if (!m_act) begin m_dev2 = (dev_sel == 2); m_pol = sel_high; end
          m_act = 1;
          m_txb = (cmd_has_tx && !cmd_verify) ? int'(cmd_data) : 0;
          m_mosi = m_txb[7];
          if (cmd_fast) m_cs2 = m_txb[6];
          m_sck = 0; m_fast = cmd_fast; m_vfy = cmd_verify; m_last = cmd_last;
          m_exp = cmd_data; m_steps = cmd_fast ? 4 : 8;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  int rxq[$];
  int last_cnt, last_fail, n_done;
  always @(negedge clk) begin
    if (rst_n && m_live) begin
      check("R3 sck", sck, m_sck);
      check("R1 mosi", mosi, m_mosi);
      check("R2 cs2", cs2, m_cs2);
      check("R5 cs0", cs0, m_act ? (m_dev2 ? !m_pol : m_pol) : 1);
      check("R5 cs1", cs1, m_act ? (m_dev2 ? m_pol : !m_pol) : 1);
      check("R10 ready", cmd_ready, !m_busy && m_gap == 0);
      check("R8 rx_valid", rx_valid, m_rv);
      check("R9 done", done, m_dn);
      if (rx_valid) begin check("R8 rx_data", rx_data, m_rxd); rxq.push_back(rx_data); end
      if (done) begin
        check("R9 done_fail", done_fail, m_fail);
        check("R11 done_count", done_count, m_cnt);
        last_cnt = done_count; last_fail = done_fail; n_done++;
      end
    end
  end

  task automatic send(int data, bit has, bit fast, bit vfy, bit last);
    @(negedge clk);
    cmd_data = 8'(data); cmd_has_tx = has; cmd_fast = fast;
    cmd_verify = vfy; cmd_last = last; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (!(cmd_ready && !cmd_valid) && n < 5000);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  int hi_len = 0, hi_max = 0, hi_min = 99;
  bit mosi_seen = 0;
  always @(negedge clk) begin
    if (sck) hi_len++;
    else if (hi_len > 0) begin
      if (hi_len > hi_max) hi_max = hi_len;
      if (hi_len < hi_min) hi_min = hi_len;
      hi_len = 0;
    end
    if (!cs1 && sck && mosi) mosi_seen = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset cs0", cs0, 1);
    check("R6 reset cs1", cs1, 1);
    check("R6 reset cs2", cs2, 1);
    check("R3 reset sck", sck, 0);
    rst_n = 1;
    @(negedge clk);
    check("R10 ready after reset", cmd_ready, 1);

    // R1 R4 R8 R11: normal bytes, divider 0 clamped to 1
    clk_div = 0; dev_sel = 0; sel_high = 0;
    resp = '{8'h5A, 8'hC3}; sbit = 0; rxq = {};
    hi_min = 99; hi_max = 0;
    send(8'hA5, 1, 0, 0, 0);
    send(8'h3C, 1, 0, 0, 1);
    wait_idle();
    check("R8 first rx byte", rxq.size() > 0 ? rxq[0] : -1, 8'h5A);
    check("R8 second rx byte", rxq.size() > 1 ? rxq[1] : -1, 8'hC3);
    check("R11 count of two", last_cnt, 2);
    check("R4 high phase clamped", hi_min, 2);
    check("R4 high phase max", hi_max, 2);

    // R2: fast write on device 2, divider 2
    clk_div = 2; dev_sel = 2; resp = {}; sbit = 0; rxq = {};
    send(8'hB4, 1, 1, 0, 0);
    send(8'h1E, 1, 1, 0, 1);
    wait_idle();
    check("R2 no rx pulse in fast mode", rxq.size(), 0);
    check("R6 cs2 idle after fast", cs2, 1);

    // R5 R7: active-high select, no transmit data
    clk_div = 1; dev_sel = 1; sel_high = 1; sbit = 0; resp = '{8'h00};
    mosi_seen = 0;
    send(8'hFF, 0, 0, 0, 1);
    wait_idle();
    check("R7 zero byte sent", mosi_seen, 0);

    // R9: mismatch in the third checked byte, rest swallowed
    clk_div = 1; dev_sel = 0; sel_high = 0; sbit = 0; n_done = 0;
    resp = '{8'h11, 8'h22, 8'h99, 8'h44, 8'h77};
    send(8'h11, 1, 0, 1, 0);
    send(8'h22, 1, 0, 1, 0);
    send(8'h33, 1, 0, 1, 0);
    send(8'h44, 1, 0, 1, 0);
    send(8'h55, 1, 0, 1, 1);
    wait_idle();
    check("R9 fail flagged", last_fail, 1);
    check("R9 good count", last_cnt, 2);
    check("R9 one close only", n_done, 1);
    sbit = 0; resp = '{8'h66};
    send(8'h66, 1, 0, 1, 1);
    wait_idle();
    check("R11 resumes after skip", last_fail, 0);
    check("R11 count after skip", last_cnt, 1);
    summary();
  end
endmodule